// File: doc/BRIEF.md
# Command Queue Pause and End-of-Queue Flag Controller

This block keeps the two sticky completion flags of one command queue in a queued ADC command engine. The first is a pause flag and the second is an end-of-queue flag. It also tracks whether the queue is IDLE or TRIGGERED.

Other logic handles command storage, the converter, serial transmission and result buffering. This block sees that logic only as a busy level and a one-cycle completion pulse. The pulse carries the pause and end-of-queue bits of the entry that has just left the queue.

The pause flag follows a rule that depends on the trigger mode:
- In edge mode it is set by completing an entry whose pause bit is set.
- In level mode it is set when a closed gate moves the queue out of TRIGGERED.
- In software mode it never sets.

A gate that closes while a transfer is in flight does not act at once. Its effect is held in a single pending bit until that transfer completes, and the bit is dropped if the gate reopens first.

Software clears each flag by writing 1 to it. Each flag has a registered, level-sensitive interrupt request that is gated by its own enable.

Top module: `cq_flag_ctrl`

## Requirements
- R1: In edge mode (`trig_mode`=1), a completion pulse with the pause bit set sets `pause_flag` on the next clock edge and returns the queue to IDLE.
- R2: In level mode (`trig_mode`=2), when a closed gate (`gate`=0) takes the queue out of TRIGGERED, `pause_flag` sets in the same cycle that `queue_trig` falls.
- R3: In software mode (`trig_mode`=0 or 3), `pause_flag` never goes from 0 to 1.
- R4: In software or level mode, completing an entry with its pause bit set leaves `pause_flag` at 0 and the queue TRIGGERED.
- R5: In level mode, if the gate is closed while TRIGGERED and no transfer is busy, or a completion pulse arrives in that cycle, the queue goes IDLE on the next edge.
- R6: In level mode, if the gate closes while a transfer is busy, the queue stays TRIGGERED with `pause_flag` clear until the completion pulse. It then goes IDLE and sets `pause_flag` on that edge.
- R7: If the gate reopens before the busy transfer completes, the deferred closure is dropped: the later completion pulse changes neither the status nor `pause_flag`.
- R8: A completion pulse with the end-of-queue bit set sets `eoq_flag` on the next edge in every trigger mode.
- R9: A write with `wr_en`=1 clears `pause_flag` when `wr_data[0]`=1 and clears `eoq_flag` when `wr_data[1]`=1. Bits written as 0 leave their flag unchanged.
- R10: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R11: The queue is TRIGGERED as follows: always in software mode; in edge mode after a rising edge of `gate` seen while IDLE; in level mode from the cycle after `gate` is seen high while IDLE. Reset leaves it IDLE.
- R12: Each interrupt request equals, one cycle later, its flag ANDed with its enable. Reset clears both requests and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_mode | input | 2 | 0/3 software, 1 edge, 2 level |
| gate | input | 1 | Trigger gate, 1 = open |
| xfer_busy | input | 1 | An entry transfer is in progress |
| xfer_done | input | 1 | One-cycle pulse: entry transfer completed |
| xfer_pause | input | 1 | Pause bit of the completed entry |
| xfer_eoq | input | 1 | End-of-queue bit of the completed entry |
| pause_ie | input | 1 | Pause interrupt enable |
| eoq_ie | input | 1 | End-of-queue interrupt enable |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | 2 | Write-1-to-clear mask: bit0 pause, bit1 end-of-queue |
| pause_flag | output | 1 | Sticky pause flag |
| eoq_flag | output | 1 | Sticky end-of-queue flag |
| queue_trig | output | 1 | Queue status, 1 = TRIGGERED, 0 = IDLE |
| pause_irq | output | 1 | Pause interrupt request |
| eoq_irq | output | 1 | End-of-queue interrupt request |

## Verification
The properties assume the following about the inputs:
- `xfer_done` is a single-cycle pulse.
- The pause and end-of-queue bits are only meaningful while `xfer_done` is high.
- `trig_mode` is held steady during a scenario.

The stimulus meets these assumptions because the queue is reset before each mode is selected, and every completion is a one-cycle pulse driven by a task that drops busy in the same cycle. Within those limits, the sweep covers every combination of mode, pause bit and end-of-queue bit. Separate scenarios cover:
- gate closure with the queue idle;
- gate closure during a busy transfer, with the completion pulse arriving later;
- gate closure during a busy transfer, with the gate reopening before completion;
- a clearing write in the same cycle as a flag set.

// File: rtl/cq_flag_ctrl.sv
module cq_flag_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] trig_mode,
  input  logic       gate,
  input  logic       xfer_busy,
  input  logic       xfer_done,
  input  logic       xfer_pause,
  input  logic       xfer_eoq,
  input  logic       pause_ie,
  input  logic       eoq_ie,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output logic       pause_flag,
  output logic       eoq_flag,
  output logic       queue_trig,
  output logic       pause_irq,
  output logic       eoq_irq
);

  localparam logic [1:0] MODE_EDGE  = 2'd1;
  localparam logic [1:0] MODE_LEVEL = 2'd2;

  logic edge_m, level_m, sw_m;
  logic gate_q, pend_q;
  logic gate_rise, closed_now, close_apply, close_defer, close_late;
  logic edge_pause, pause_set, eoq_set;
  logic pause_clr, eoq_clr;
  logic trig_d, pend_d;

  assign edge_m  = (trig_mode == MODE_EDGE);
  assign level_m = (trig_mode == MODE_LEVEL);
  assign sw_m    = !edge_m && !level_m;

  assign gate_rise  = gate && !gate_q;
  assign closed_now = level_m && queue_trig && !gate;

  // closure with no transfer in flight, or one ending this cycle
  assign close_apply = closed_now && !pend_q && (!xfer_busy || xfer_done);
  // closure seen mid-transfer: remember it
  assign close_defer = closed_now && !pend_q && xfer_busy && !xfer_done;
  // remembered closure reaches the end of its transfer
  assign close_late  = level_m && pend_q && !gate && xfer_done;

  assign edge_pause = edge_m && xfer_done && xfer_pause;
  assign pause_set  = edge_pause || close_apply || close_late;
  assign eoq_set    = xfer_done && xfer_eoq;

  assign pause_clr = wr_en && wr_data[0];
  assign eoq_clr   = wr_en && wr_data[1];

  always_comb begin
    trig_d = queue_trig;
    if (sw_m)
      trig_d = 1'b1;
    else if (edge_m) begin
      if (queue_trig && edge_pause)
        trig_d = 1'b0;
      else if (!queue_trig && gate_rise)
        trig_d = 1'b1;
    end else begin
      if (close_apply || close_late)
        trig_d = 1'b0;
      else if (!queue_trig && gate)
        trig_d = 1'b1;
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (!level_m || gate || close_late)
      pend_d = 1'b0;
    else if (close_defer)
      pend_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q     <= 1'b0;
      pend_q     <= 1'b0;
      queue_trig <= 1'b0;
      pause_flag <= 1'b0;
      eoq_flag   <= 1'b0;
      pause_irq  <= 1'b0;
      eoq_irq    <= 1'b0;
    end else begin
      gate_q     <= gate;
      pend_q     <= pend_d;
      queue_trig <= trig_d;
      pause_flag <= pause_set || (pause_flag && !pause_clr);
      eoq_flag   <= eoq_set || (eoq_flag && !eoq_clr);
      pause_irq  <= pause_flag && pause_ie;
      eoq_irq    <= eoq_flag && eoq_ie;
    end
  end

endmodule

// File: rtl/cq_flag_ctrl_chk.sv
module cq_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] trig_mode,
  input logic       gate,
  input logic       xfer_busy,
  input logic       xfer_done,
  input logic       xfer_pause,
  input logic       xfer_eoq,
  input logic       pause_ie,
  input logic       eoq_ie,
  input logic       wr_en,
  input logic [1:0] wr_data,
  input logic       pause_flag,
  input logic       eoq_flag,
  input logic       queue_trig,
  input logic       pause_irq,
  input logic       eoq_irq
);

  AST_EDGE_PAUSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode == 2'd1 && xfer_done && xfer_pause) |=> pause_flag); // R1

  AST_LEVEL_CLOSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode == 2'd2 && queue_trig && !gate && !xfer_busy) |=> (!queue_trig && pause_flag)); // R5

  AST_SW_NO_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_mode == 2'd0 || trig_mode == 2'd3) && !pause_flag) |=> !pause_flag); // R3

  AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode == 2'd2 && queue_trig && xfer_busy && !xfer_done) |=> queue_trig); // R6

  AST_EOQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && xfer_eoq) |=> eoq_flag); // R8

  AST_PAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_flag && !(wr_en && wr_data[0])) |=> pause_flag); // R9

  AST_EOQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (eoq_flag && !(wr_en && wr_data[1])) |=> eoq_flag); // R9

  AST_PAUSE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_flag && pause_ie) |=> pause_irq); // R12

  AST_EOQ_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoq_flag || !eoq_ie) |=> !eoq_irq); // R12

endmodule

bind cq_flag_ctrl cq_flag_ctrl_chk u_chk (.*);

// File: tb/cq_flag_ctrl_test.sv
module cq_flag_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] trig_mode;
  logic       gate, xfer_busy, xfer_done, xfer_pause, xfer_eoq;
  logic       pause_ie, eoq_ie, wr_en;
  logic [1:0] wr_data;
  logic       pause_flag, eoq_flag, queue_trig, pause_irq, eoq_irq;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cq_flag_ctrl uut (.*);

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] m);
    rst_n = 1'b0; trig_mode = m; gate = 1'b0; xfer_busy = 1'b0;
    xfer_done = 1'b0; xfer_pause = 1'b0; xfer_eoq = 1'b0;
    pause_ie = 1'b1; eoq_ie = 1'b1; wr_en = 1'b0; wr_data = 2'b00;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic complete(logic p, logic e);
    xfer_done = 1'b1; xfer_pause = p; xfer_eoq = e; xfer_busy = 1'b0;
    step();
    xfer_done = 1'b0; xfer_pause = 1'b0; xfer_eoq = 1'b0;
  endtask

  task automatic bring_up(logic [1:0] m);
    do_reset(m);
    if (m == 2'd1) begin
      step(); chk("R11 edge idle before gate", queue_trig, 1'b0);
      gate = 1'b1; step(); chk("R11 edge trigger", queue_trig, 1'b1);
      gate = 1'b0; step();
    end else if (m == 2'd2) begin
      gate = 1'b1; step(); chk("R11 level trigger", queue_trig, 1'b1);
    end else begin
      step(); chk("R11 software trigger", queue_trig, 1'b1);
    end
  endtask

  initial begin
    do_reset(2'd0);
    chk("R12 reset pause_flag", pause_flag, 1'b0);
    chk("R12 reset eoq_flag", eoq_flag, 1'b0);
    chk("R11 reset idle", queue_trig, 1'b0);
    chk("R12 reset irq", pause_irq | eoq_irq, 1'b0);

    for (int m = 0; m < 4; m++) begin
      for (int pe = 0; pe < 4; pe++) begin
        logic p, e, ep;
        p = pe[0]; e = pe[1];
        ep = (m == 1) && p;
        bring_up(m[1:0]);
        complete(p, e);
        chk(ep ? "R1 pause set" : (p ? "R4 pause ignored" : "R3 no pause"), pause_flag, ep);
        chk("R8 eoq set", eoq_flag, e);
        chk(ep ? "R1 queue idle" : "R4 stays triggered", queue_trig, !ep);
        chk("R12 irq one cycle late", pause_irq | eoq_irq, 1'b0);
        step();
        chk("R12 pause irq", pause_irq, ep);
        chk("R12 eoq irq", eoq_irq, e);
        wr_en = 1'b1; wr_data = 2'b00; step();
        chk("R9 write zero pause", pause_flag, ep);
        chk("R9 write zero eoq", eoq_flag, e);
        wr_data = 2'b01; step();
        chk("R9 clear pause only", pause_flag, 1'b0);
        chk("R9 eoq kept", eoq_flag, e);
        wr_data = 2'b10; step();
        chk("R9 clear eoq", eoq_flag, 1'b0);
        wr_en = 1'b0; wr_data = 2'b00;
      end
    end

    // level close with nothing in flight
    bring_up(2'd2);
    gate = 1'b0; step();
    chk("R5 immediate idle", queue_trig, 1'b0);
    chk("R2 pause on close", pause_flag, 1'b1);
    step();
    chk("R12 irq after close", pause_irq, 1'b1);

    // close during a busy transfer
    bring_up(2'd2);
    xfer_busy = 1'b1; step();
    gate = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R6 held triggered", queue_trig, 1'b1);
      chk("R6 pause held off", pause_flag, 1'b0);
    end
    complete(1'b0, 1'b0);
    chk("R6 idle at completion", queue_trig, 1'b0);
    chk("R2 pause at completion", pause_flag, 1'b1);

    // reopen before completion
    bring_up(2'd2);
    xfer_busy = 1'b1; step();
    gate = 1'b0; step();
    gate = 1'b1; step();
    complete(1'b0, 1'b0);
    chk("R7 cancelled stays triggered", queue_trig, 1'b1);
    chk("R7 cancelled no pause", pause_flag, 1'b0);
    step();
    chk("R7 still triggered", queue_trig, 1'b1);

    // set beats clear
    bring_up(2'd1);
    wr_en = 1'b1; wr_data = 2'b11;
    complete(1'b1, 1'b1);
    wr_en = 1'b0; wr_data = 2'b00;
    chk("R10 pause set wins", pause_flag, 1'b1);
    chk("R10 eoq set wins", eoq_flag, 1'b1);

    // edge retrigger after pause
    gate = 1'b1; step();
    chk("R11 edge retrigger", queue_trig, 1'b1);
    step();
    chk("R11 no retrigger without edge", queue_trig, 1'b1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      misses++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule